// File: doc/BRIEF.md
# Dual-Strobe Burst Access Controller

This block is the clocked front end of a pipelined burst memory. On every rising clock edge it takes in an address, three chip selects, two address strobes, a burst step input and a set of write controls. From these it decides whether the cycle starts a new access, continues the one in progress, or deselects the device. One strobe belongs to a processor and the other to a cache controller. The processor strobe has fixed priority over the controller strobe, and an access opened by the processor strobe is always a read on its first cycle.

A two-bit wraparound counter produces the low address bits of each burst. A static mode input selects the order: interleaved (the start offset XOR the beat count) or linear (the start offset plus the beat count, modulo four). Write controls become per-lane write strobes into a parameterized array of four 9-bit lanes. A global write overrides the byte selects. Each request passes through one request register. The array is written, or read into a read data register, on the edge after that.

Top module: `dsb_access_ctrl`

## Requirements
- R1: When both strobes are low on the same edge and `sel_a_n_i` is low, only the processor strobe is taken. The cycle is then a read (if selected) even when the write controls are active, and the array is not written.
- R2: The processor strobe is ignored while `sel_a_n_i` is high; with the controller strobe also high the cycle is a burst continue. The chip is selected only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. A taken strobe with the chip not selected ends any active access. `sel_b_i` and `sel_c_n_i` have no effect on cycles without a taken strobe.
- R3: A processor-strobe access reads the loaded address on its first cycle and ignores the write and step inputs there. A following continue cycle with active write controls writes the burst address of that cycle.
- R4: A controller-strobe access with the processor strobe not taken writes the loaded address in that single cycle when the write controls are active. `step_n_i` is ignored on that cycle.
- R5: Any selected strobe loads address bits [1:0] as the burst start and resets the beat count. On a continue cycle with `step_n_i`=0 the count advances by one (mod 4) before the access. With `step_n_i`=1 the current address is reused.
- R6: With `mode_ilv_i`=1 the low address bits of a beat are start XOR count (start 2 gives 2,3,0,1; start 1 gives 1,0,3,2).
- R7: With `mode_ilv_i`=0 the low address bits are (start + count) mod 4. Start 3 gives 3,0,1,2 and returns to 3 after the fourth beat.
- R8: `wr_all_n_i`=0 writes all four lanes. Otherwise `wr_byte_n_i`=0 writes exactly the lanes whose `lane_sel_n_i` bit is 0, and lane i is data bits [9i+8:9i]. Unwritten lanes keep their contents.
- R9: A cycle writes only when `wr_all_n_i`=0, or when `wr_byte_n_i`=0 with at least one `lane_sel_n_i` bit low. Any other combination is a read.
- R10: A continue cycle when no access is active performs neither a read nor a write.
- R11: For a request sampled at edge k, `wr_strb_o` shows its lanes during the cycle after edge k and the array is written at edge k+1. A read sets `rvalid_o` with the data on `rdata_o` for the one cycle after edge k+1.
- R12: After reset `rvalid_o` is low, `wr_strb_o` is zero and no access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr_i | input | AW | Word address loaded on a taken strobe |
| sel_a_n_i | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_n_i | input | 1 | Chip select C, active low |
| cpu_stb_n_i | input | 1 | Processor address strobe, active low, higher priority |
| ctl_stb_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Global write, active low |
| wr_byte_n_i | input | 1 | Byte write enable, active low |
| lane_sel_n_i | input | 4 | Per-lane byte selects, active low |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Read data register |
| rvalid_o | output | 1 | Read data valid |
| wr_strb_o | output | 4 | Lane write strobes of the pending request |
| arr_addr_o | output | AW | Array address of the pending request |

## Verification
Strobe arbitration and write decode meet on one edge when both strobes are low with global write active. The processor strobe must win, so the cycle must read back the old word and leave the array alone. A second case is a processor-strobe start followed by a write continue, where the write must land two edges after the strobe on the burst address of that continue. The scoreboard settles both by reading the affected words back and comparing them with its own memory image. It also checks the exact cycles of `wr_strb_o` and `rvalid_o`.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BURST_W = 2;
endpackage

// File: rtl/dsb_strobe_decode.sv
module dsb_strobe_decode #(
    parameter int LANES = 4
) (
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic             cpu_take,
    output logic             ctl_take,
    output logic             chip_on,
    output logic             wr_req,
    output logic [LANES-1:0] lane_be
);
    // processor strobe wins; it is gated by select A
    assign cpu_take = !cpu_stb_n && !sel_a_n;
    assign ctl_take = !cpu_take && !ctl_stb_n;
    assign chip_on  = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        if (!wr_all_n) begin
            lane_be = '1;
        end else if (!wr_byte_n) begin
            lane_be = ~lane_sel_n;
        end else begin
            lane_be = '0;
        end
    end

    assign wr_req = |lane_be;
endmodule

// File: rtl/dsb_burst_seq.sv
module dsb_burst_seq #(
    parameter int BW = 2
) (
    input  logic          ilv,
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] cnt,
    output logic [BW-1:0] lo
);
    logic [BW-1:0] lo_xor;
    logic [BW-1:0] lo_add;

    genvar g;
    for (g = 0; g < BW; g++) begin : g_bit
        assign lo_xor[g] = start[g] ^ cnt[g];
    end

    assign lo_add = start + cnt;
    assign lo     = ilv ? lo_xor : lo_add;
endmodule

// File: rtl/dsb_lane_array.sv
module dsb_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_en,
    input  logic                    rd_en,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    genvar g;
    for (g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                rd_q <= mem[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/dsb_access_ctrl.sv
module dsb_access_ctrl
    import dsb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ilv_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              cpu_stb_n_i,
    input  logic              ctl_stb_n_i,
    input  logic              step_n_i,
    input  logic              wr_all_n_i,
    input  logic              wr_byte_n_i,
    input  logic [LANES-1:0]  lane_sel_n_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic [LANES-1:0]  wr_strb_o,
    output logic [AW-1:0]     arr_addr_o
);
    localparam int HI_W = AW - BURST_W;

    typedef struct packed {
        logic                active;
        logic [HI_W-1:0]     base;
        logic [BURST_W-1:0]  start;
        logic [BURST_W-1:0]  cnt;
        logic                req_vld;
        logic                req_wr;
        logic [LANES-1:0]    req_be;
        logic [AW-1:0]       req_addr;
        logic [WORD_W-1:0]   req_data;
        logic                rvalid;
    } st_t;

    st_t st_d, st_q;

    logic               cpu_take, ctl_take, chip_on, wr_req;
    logic [LANES-1:0]   lane_be;
    logic [BURST_W-1:0] cnt_nx;
    logic [BURST_W-1:0] beat_lo;

    dsb_strobe_decode #(.LANES(LANES)) u_dec (
        .cpu_stb_n  (cpu_stb_n_i),
        .ctl_stb_n  (ctl_stb_n_i),
        .sel_a_n    (sel_a_n_i),
        .sel_b      (sel_b_i),
        .sel_c_n    (sel_c_n_i),
        .wr_all_n   (wr_all_n_i),
        .wr_byte_n  (wr_byte_n_i),
        .lane_sel_n (lane_sel_n_i),
        .cpu_take   (cpu_take),
        .ctl_take   (ctl_take),
        .chip_on    (chip_on),
        .wr_req     (wr_req),
        .lane_be    (lane_be)
    );

    assign cnt_nx = step_n_i ? st_q.cnt : st_q.cnt + 1'b1;

    dsb_burst_seq #(.BW(BURST_W)) u_seq (
        .ilv   (mode_ilv_i),
        .start (st_q.start),
        .cnt   (cnt_nx),
        .lo    (beat_lo)
    );

    always_comb begin
        st_d          = st_q;
        st_d.req_vld  = 1'b0;
        st_d.req_wr   = 1'b0;
        st_d.req_be   = '0;
        st_d.req_data = wdata_i;
        st_d.rvalid   = st_q.req_vld && !st_q.req_wr;

        if (cpu_take || ctl_take) begin
            if (chip_on) begin
                st_d.active   = 1'b1;
                st_d.base     = addr_i[AW-1:BURST_W];
                st_d.start    = addr_i[BURST_W-1:0];
                st_d.cnt      = '0;
                st_d.req_vld  = 1'b1;
                st_d.req_addr = addr_i;
                // processor strobe always opens with a read
                st_d.req_wr   = ctl_take && wr_req;
                st_d.req_be   = ctl_take ? lane_be : '0;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.cnt      = cnt_nx;
            st_d.req_vld  = 1'b1;
            st_d.req_addr = {st_q.base, beat_lo};
            st_d.req_wr   = wr_req;
            st_d.req_be   = lane_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_strb_o  = (st_q.req_vld && st_q.req_wr) ? st_q.req_be : '0;
    assign arr_addr_o = st_q.req_addr;
    assign rvalid_o   = st_q.rvalid;

    dsb_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .wr_en (wr_strb_o),
        .rd_en (st_q.req_vld && !st_q.req_wr),
        .addr  (st_q.req_addr),
        .wdata (st_q.req_data),
        .rdata (rdata_o)
    );
endmodule

// File: rtl/dsb_access_ctrl_chk.sv
module dsb_access_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_a_n_i,
    input logic             sel_b_i,
    input logic             sel_c_n_i,
    input logic             cpu_stb_n_i,
    input logic             ctl_stb_n_i,
    input logic             wr_all_n_i,
    input logic             wr_byte_n_i,
    input logic [LANES-1:0] lane_sel_n_i,
    input logic             rvalid_o,
    input logic [LANES-1:0] wr_strb_o
);
    logic chip_sel;
    assign chip_sel = !sel_a_n_i && sel_b_i && !sel_c_n_i;

    AST_CPU_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n_i && !sel_a_n_i) |=> (wr_strb_o == '0)); // R3

    AST_CPU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n_i && !ctl_stb_n_i && chip_sel) |=> (wr_strb_o == '0) ##1 rvalid_o); // R1

    AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n_i && !sel_b_i) |=> (wr_strb_o == '0) ##1 !rvalid_o); // R2

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n_i && !ctl_stb_n_i && chip_sel && !wr_all_n_i) |=> (wr_strb_o == '1)); // R8

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n_i && !ctl_stb_n_i && chip_sel && wr_all_n_i && !wr_byte_n_i)
        |=> (wr_strb_o == ~$past(lane_sel_n_i))); // R8

    AST_NO_LANE_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n_i && !ctl_stb_n_i && chip_sel && wr_all_n_i && (&lane_sel_n_i))
        |=> (wr_strb_o == '0) ##1 rvalid_o); // R9
endmodule

bind dsb_access_ctrl dsb_access_ctrl_chk #(.LANES(dsb_pkg::LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_a_n_i    (sel_a_n_i),
    .sel_b_i      (sel_b_i),
    .sel_c_n_i    (sel_c_n_i),
    .cpu_stb_n_i  (cpu_stb_n_i),
    .ctl_stb_n_i  (ctl_stb_n_i),
    .wr_all_n_i   (wr_all_n_i),
    .wr_byte_n_i  (wr_byte_n_i),
    .lane_sel_n_i (lane_sel_n_i),
    .rvalid_o     (rvalid_o),
    .wr_strb_o    (wr_strb_o)
);

// File: tb/dsb_access_ctrl_bench.sv
module dsb_access_ctrl_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ilv_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic        sel_a_n_i = 1'b1, sel_b_i = 1'b1, sel_c_n_i = 1'b0;
    logic        cpu_stb_n_i = 1'b1, ctl_stb_n_i = 1'b1, step_n_i = 1'b1;
    logic        wr_all_n_i = 1'b1, wr_byte_n_i = 1'b1;
    logic [3:0]  lane_sel_n_i = 4'hF;
    logic [35:0] wdata_i = '0;
    logic [35:0] rdata_o;
    logic        rvalid_o;
    logic [3:0]  wr_strb_o;
    logic [AW-1:0] arr_addr_o;

    always #10 clk = ~clk;

    dsb_access_ctrl #(.AW(AW)) u_dsb_access_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_ilv_i(mode_ilv_i), .addr_i(addr_i),
        .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
        .cpu_stb_n_i(cpu_stb_n_i), .ctl_stb_n_i(ctl_stb_n_i), .step_n_i(step_n_i),
        .wr_all_n_i(wr_all_n_i), .wr_byte_n_i(wr_byte_n_i), .lane_sel_n_i(lane_sel_n_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .wr_strb_o(wr_strb_o), .arr_addr_o(arr_addr_o)
    );

    typedef struct {
        logic [35:0]   data;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [35:0] m_mem [DEPTH];
    logic        m_active = 1'b0;
    logic [AW-3:0] m_base = '0;
    logic [1:0]  m_start = '0, m_cnt = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int i);
        return 36'(i) * 36'h1_2345_6789 ^ 36'h9_5A5A_5A5A;
    endfunction

    // one bus cycle: drive at the falling edge, update the reference image
    task automatic drive(input logic pn, cn, san, sb, scn, stn, gwn, bwn,
                         input logic [3:0] bsn, input logic [AW-1:0] a,
                         input logic [35:0] wd, input string tag);
        logic p_take, c_take, on, wr, acc, acc_wr;
        logic [3:0] be;
        logic [AW-1:0] acc_a;
        @(negedge clk);
        cpu_stb_n_i = pn; ctl_stb_n_i = cn; sel_a_n_i = san; sel_b_i = sb;
        sel_c_n_i = scn; step_n_i = stn; wr_all_n_i = gwn; wr_byte_n_i = bwn;
        lane_sel_n_i = bsn; addr_i = a; wdata_i = wd;
        p_take = !pn && !san;
        c_take = !p_take && !cn;
        on     = !san && sb && !scn;
        be     = !gwn ? 4'hF : (!bwn ? ~bsn : 4'h0);
        wr     = (be != 4'h0);
        acc = 1'b0; acc_wr = 1'b0; acc_a = '0;
        if (p_take || c_take) begin
            if (on) begin
                m_active = 1'b1; m_base = a[AW-1:2]; m_start = a[1:0]; m_cnt = 2'd0;
                acc = 1'b1; acc_a = a; acc_wr = c_take && wr;
            end else begin
                m_active = 1'b0;
            end
        end else if (m_active) begin
            if (!stn) m_cnt = m_cnt + 2'd1;
            acc = 1'b1; acc_wr = wr;
            acc_a = {m_base, mode_ilv_i ? (m_start ^ m_cnt) : (m_start + m_cnt)};
        end
        if (acc) begin
            if (acc_wr) begin
                for (int l = 0; l < 4; l++)
                    if (be[l]) m_mem[acc_a][l*9 +: 9] = wd[l*9 +: 9];
            end else begin
                exp_q.push_back('{data: m_mem[acc_a], addr: acc_a, tag: tag});
            end
        end
    endtask

    task automatic c_write(input logic [AW-1:0] a, input logic gwn, bwn, input logic [3:0] bsn,
                           input logic [35:0] wd, input logic stn, input string tag);
        drive(1, 0, 0, 1, 0, stn, gwn, bwn, bsn, a, wd, tag);
    endtask
    task automatic c_read(input logic [AW-1:0] a, input string tag);
        drive(1, 0, 0, 1, 0, 1, 1, 1, 4'hF, a, '0, tag);
    endtask
    task automatic p_read(input logic [AW-1:0] a, input logic gwn, input string tag);
        drive(0, 1, 0, 1, 0, 0, gwn, 0, 4'h0, a, 36'hF_FFFF_FFFF, tag);
    endtask
    task automatic cont(input logic stn, gwn, bwn, input logic [3:0] bsn,
                        input logic [35:0] wd, input string tag);
        drive(1, 1, 0, 1, 0, stn, gwn, bwn, bsn, '0, wd, tag);
    endtask
    task automatic desel();
        drive(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, '0, '0, "R10");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", rdata_o, 'x);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rdata_o === e.data, e.tag, rdata_o, e.data);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11: watchdog expired, actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rvalid_o == 1'b0, "R12", 36'(rvalid_o), 36'd0);
        chk(wr_strb_o == 4'h0, "R12", 36'(wr_strb_o), 36'd0);
        desel();
        chk(rvalid_o == 1'b0, "R12", 36'(rvalid_o), 36'd0);

        // fill the array with global writes (R4, R8)
        for (int i = 0; i < DEPTH; i++) c_write(AW'(i), 0, 1, 4'hF, pat(i), 1, "R4");
        desel();

        // R11: exact cycle of write strobes and read data
        c_write(6'd9, 1, 0, 4'b1100, 36'h0_0000_0AAA, 1, "R11");
        desel();
        chk(wr_strb_o == 4'b0011, "R11", 36'(wr_strb_o), 36'h3);
        c_read(6'd9, "R11");
        desel();
        chk(rvalid_o == 1'b0, "R11", 36'(rvalid_o), 36'd0);
        desel();
        chk(rvalid_o == 1'b1, "R11", 36'(rvalid_o), 36'd1);

        // R4: step input ignored on controller write
        c_write(6'd5, 0, 1, 4'hF, 36'h1_1111_1111, 0, "R4");
        c_read(6'd5, "R4");
        c_read(6'd6, "R4");

        // R6: interleaved order, start 2 and start 1, with wrap
        mode_ilv_i = 1'b1;
        c_read(6'd18, "R6");
        for (int k = 0; k < 4; k++) cont(0, 1, 1, 4'hF, '0, "R6");
        c_read(6'd33, "R6");
        for (int k = 0; k < 3; k++) cont(0, 1, 1, 4'hF, '0, "R6");
        desel();

        // R7: linear order, start 3, wraps back to 3
        mode_ilv_i = 1'b0;
        c_read(6'd43, "R7");
        for (int k = 0; k < 4; k++) cont(0, 1, 1, 4'hF, '0, "R7");
        desel();

        // R5: suspend holds, then step moves
        c_read(6'd20, "R5");
        cont(1, 1, 1, 4'hF, '0, "R5");
        cont(1, 1, 1, 4'hF, '0, "R5");
        cont(0, 1, 1, 4'hF, '0, "R5");
        c_read(6'd23, "R5");
        desel();

        // R3: processor start ignores write, write on next cycle same address
        mode_ilv_i = 1'b1;
        p_read(6'd12, 0, "R3");
        cont(1, 0, 1, 4'hF, 36'h2_2222_2222, "R3");
        cont(0, 1, 0, 4'b0111, 36'h3_3333_3333, "R3");
        c_read(6'd12, "R3");
        c_read(6'd13, "R3");

        // R1: both strobes low, global write active -> read, no write
        drive(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 6'd30, 36'h4_4444_4444, "R1");
        c_read(6'd30, "R1");

        // R2: processor strobe ignored with select A high -> continue burst
        c_read(6'd40, "R2");
        drive(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, 6'd0, '0, "R2");
        drive(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, '0, "R2");
        // select C inactive on a processor strobe -> deselect
        drive(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 6'd50, '0, "R2");
        // R10: continue after deselect does nothing, even with global write
        cont(0, 0, 1, 4'hF, 36'h5_5555_5555, "R10");
        cont(1, 1, 1, 4'hF, '0, "R10");
        c_read(6'd40, "R10");
        c_read(6'd41, "R10");
        c_read(6'd50, "R10");

        // R8: byte lanes and global override
        c_write(6'd60, 1, 0, 4'b1010, 36'h6_6666_6666, 1, "R8");
        c_read(6'd60, "R8");
        c_write(6'd61, 0, 0, 4'b1110, 36'h7_7777_7777, 1, "R8");
        c_read(6'd61, "R8");

        // R9: byte enable with no lane, and lanes without byte enable, are reads
        c_write(6'd62, 1, 0, 4'hF, 36'h8_8888_8888, 1, "R9");
        c_write(6'd62, 1, 1, 4'h0, 36'h8_8888_8888, 1, "R9");
        c_read(6'd62, "R9");

        repeat (4) desel();
        chk(exp_q.size() == 0, "R11", 36'(exp_q.size()), 36'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule